// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a watchdog counter behind a small register port. Four word registers sit on a two-bit address: control/status (0), counter (1), timeout value (2) and refresh window (3). Software cannot change configuration until it writes an unlock key to the counter register. The key is either a pair of 16-bit halves or one 32-bit word, depending on a wide-command bit. It keeps the counter alive by writing a different refresh key to the same register.

The counter advances on one of four tick sources: the bus clock, or one of three enable pulses from a low-power clock, a slow clock and an external clock. A fixed divide-by-256 prescaler can be placed in front of it. When the count reaches the timeout value, the block sets a flag, may raise an interrupt, and pulses a reset request. A nonzero window value turns a refresh that comes too early into a reset request. Two status bits report progress to software. The unlocked bit shows that the unlock key was accepted. The reconfiguration-complete bit shows that a control write has settled.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, control reads 0x0000_0420 (update-allowed bit 5 and reconfig-complete bit 10 set). Timeout reads 0x0000_FFFF, window and counter read 0, and irq_o and rst_req_o are low.
- R2: With control bit 13 clear, writing 0xC520 and then, as the very next bus write, 0xD928 to the counter register sets unlocked bit 11 from the following cycle.
- R3: A wrong second half, or any other bus write between the two halves, abandons the key pair with no effect. A later lone second half does not unlock.
- R4: With control bit 13 set, the single write 0xD928C520 unlocks and the single write 0xB480A602 refreshes. The 16-bit halves do nothing in that mode.
- R5: While bit 11 is clear, writes to the timeout, window and control registers are ignored. The one exception is the flag clear of R11.
- R6: Bit 11 falls after UNLK_CYC (default 16) cycles, or on the cycle after an accepted control write.
- R7: An accepted control write clears bit 10. Bit 10 returns to 1 after RCFG_CYC (default 3) cycles.
- R8: With bit 13 clear, writing 0xA602 and then 0xB480 to the counter register clears the count to 0.
- R9: When enable bit 7 is set, the count advances once per tick of the source picked by bits 9:8 (0 bus clock, 1 lpo_tick_i, 2 slow_tick_i, 3 ext_tick_i). Ticks of the other sources are not counted.
- R10: With prescaler bit 12 set, the count advances once per 256 source ticks. The prescaler restarts on a refresh or an accepted control write.
- R11: On the tick that would bring the count to the timeout value, the count returns to 0, flag bit 14 sets and rst_req_o pulses for one cycle. irq_o follows the flag while interrupt-enable bit 6 is set. Writing 1 to bit 14 clears the flag, even while locked.
- R12: With a nonzero window, a refresh taken while the count is below the window value pulses rst_req_o. A refresh at or above the window value does not.
- R13: An accepted control write with update-allowed bit 5 clear makes every later unlock key ineffective.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | bus clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| bus_we_i | input | 1 | write strobe, one write per cycle |
| bus_addr_i | input | 2 | register select: 0 control, 1 counter, 2 timeout, 3 window |
| bus_wdata_i | input | 32 | write data |
| bus_rdata_o | output | 32 | read data for bus_addr_i (combinational) |
| lpo_tick_i | input | 1 | low-power clock enable pulse |
| slow_tick_i | input | 1 | slow clock enable pulse |
| ext_tick_i | input | 1 | external clock enable pulse |
| irq_o | output | 1 | timeout interrupt |
| rst_req_o | output | 1 | one-cycle reset request |

## Verification
The assertions check, on every cycle, the invariants that cannot fail silently between scenarios. A pending key half never survives another bus write, and an unlock and a refresh never decode together. The count stays frozen unless a tick or a clear occurs, and a timeout wraps it to zero. Locked timeout writes leave the register untouched, and a control write closes the unlock window and drops reconfig-complete. No unlock appears once updates are frozen, and a rising flag comes with a reset request. Only the bench scenarios can show the exact cycle counts: how long the window stays open, how long reconfiguration takes, the timeout and prescaler tick counts, the decode of each source select, and the window-violation boundary.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_UNLK, SEQ_RFSH} seq_e;
  typedef enum logic [1:0] {REG_CTRL = 2'd0, REG_CNT = 2'd1, REG_TOVAL = 2'd2, REG_WIN = 2'd3} reg_e;
  typedef enum logic [1:0] {SRC_BUS = 2'd0, SRC_LPO = 2'd1, SRC_SLOW = 2'd2, SRC_EXT = 2'd3} src_e;

  localparam logic [15:0] UNLK_LO = 16'hC520;
  localparam logic [15:0] UNLK_HI = 16'hD928;
  localparam logic [15:0] RFSH_LO = 16'hA602;
  localparam logic [15:0] RFSH_HI = 16'hB480;
  localparam logic [31:0] UNLK_W  = {UNLK_HI, UNLK_LO};
  localparam logic [31:0] RFSH_W  = {RFSH_HI, RFSH_LO};

  // control/status bit positions
  localparam int B_UPD  = 5;
  localparam int B_IE   = 6;
  localparam int B_EN   = 7;
  localparam int B_SEL  = 8;
  localparam int B_RCS  = 10;
  localparam int B_ULK  = 11;
  localparam int B_PRES = 12;
  localparam int B_WIDE = 13;
  localparam int B_FLG  = 14;
endpackage

// File: rtl/wdk_keyseq.sv
module wdk_keyseq
  import wdk_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic        cnt_wr_i,
  input  logic [31:0] data_i,
  input  logic        wide_i,
  output logic        unlock_o,
  output logic        refresh_o
);
  seq_e st_q, st_d;

  always_comb begin
    if (wide_i) begin
      unlock_o  = cnt_wr_i && (data_i == UNLK_W);
      refresh_o = cnt_wr_i && (data_i == RFSH_W);
    end else begin
      unlock_o  = cnt_wr_i && (st_q == SEQ_UNLK) && (data_i[15:0] == UNLK_HI);
      refresh_o = cnt_wr_i && (st_q == SEQ_RFSH) && (data_i[15:0] == RFSH_HI);
    end
  end

  // any write either opens a pair from idle or closes a pending one
  always_comb begin
    st_d = st_q;
    if (wr_i) begin
      st_d = SEQ_IDLE;
      if (cnt_wr_i && !wide_i && st_q == SEQ_IDLE) begin
        if (data_i[15:0] == UNLK_LO)      st_d = SEQ_UNLK;
        else if (data_i[15:0] == RFSH_LO) st_d = SEQ_RFSH;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SEQ_IDLE;
    else         st_q <= st_d;
  end

  assert_keys_exclusive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({unlock_o, refresh_o}));

  assert_pair_consumed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && st_q != SEQ_IDLE) |=> st_q == SEQ_IDLE);
endmodule

// File: rtl/wdk_count.sv
module wdk_count
  import wdk_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       sel_i,
  input  logic             pre_en_i,
  input  logic             lpo_tick_i,
  input  logic             slow_tick_i,
  input  logic             ext_tick_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] toval_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tmo_o
);
  logic [CNT_W-1:0] cnt_q, cnt_inc;
  logic [PRE_W-1:0] pre_q;
  logic             raw, tick;

  always_comb begin
    unique case (src_e'(sel_i))
      SRC_BUS:  raw = 1'b1;
      SRC_LPO:  raw = lpo_tick_i;
      SRC_SLOW: raw = slow_tick_i;
      default:  raw = ext_tick_i;
    endcase
  end

  assign tick    = en_i && raw && (!pre_en_i || (&pre_q));
  assign cnt_inc = cnt_q + CNT_W'(1);
  assign tmo_o   = tick && !clr_i && (cnt_inc == toval_i);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      if (clr_i)                           pre_q <= '0;
      else if (en_i && raw && pre_en_i)    pre_q <= pre_q + PRE_W'(1);
      if (clr_i)      cnt_q <= '0;
      else if (tmo_o) cnt_q <= '0;
      else if (tick)  cnt_q <= cnt_inc;
    end
  end

  assert_count_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !(en_i && raw)) |=> $stable(cnt_q));

  assert_timeout_wrap_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |=> cnt_q == '0);
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdk_pkg::*;
#(
  parameter int          CNT_W      = 16,
  parameter int          PRE_W      = 8,
  parameter int          UNLK_CYC   = 16,
  parameter int          RCFG_CYC   = 3,
  parameter logic [15:0] TOVAL_INIT = 16'hFFFF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_we_i,
  input  logic [1:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  input  logic        lpo_tick_i,
  input  logic        slow_tick_i,
  input  logic        ext_tick_i,
  output logic        irq_o,
  output logic        rst_req_o
);
  localparam int UT_W = $clog2(UNLK_CYC + 1);
  localparam int RT_W = $clog2(RCFG_CYC + 1);

  logic             upd_q, ie_q, en_q, pres_q, wide_q, flg_q, ulk_q, rcs_q, rst_req_q;
  logic [1:0]       sel_q;
  logic [CNT_W-1:0] toval_q, win_q, cnt;
  logic [UT_W-1:0]  ut_q;
  logic [RT_W-1:0]  rt_q;
  logic             wr_ctrl, wr_cnt, wr_toval, wr_win, cfg_ok;
  logic             key_unlock, key_refresh, tmo, win_viol;

  assign wr_ctrl  = bus_we_i && (reg_e'(bus_addr_i) == REG_CTRL);
  assign wr_cnt   = bus_we_i && (reg_e'(bus_addr_i) == REG_CNT);
  assign wr_toval = bus_we_i && (reg_e'(bus_addr_i) == REG_TOVAL);
  assign wr_win   = bus_we_i && (reg_e'(bus_addr_i) == REG_WIN);
  assign cfg_ok   = wr_ctrl && ulk_q;

  wdk_keyseq u_keys (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (bus_we_i),
    .cnt_wr_i  (wr_cnt),
    .data_i    (bus_wdata_i),
    .wide_i    (wide_q),
    .unlock_o  (key_unlock),
    .refresh_o (key_refresh)
  );

  wdk_count #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_q),
    .sel_i       (sel_q),
    .pre_en_i    (pres_q),
    .lpo_tick_i  (lpo_tick_i),
    .slow_tick_i (slow_tick_i),
    .ext_tick_i  (ext_tick_i),
    .clr_i       (key_refresh || cfg_ok),
    .toval_i     (toval_q),
    .cnt_o       (cnt),
    .tmo_o       (tmo)
  );

  assign win_viol = key_refresh && (win_q != '0) && (cnt < win_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_q   <= 1'b1;
      ie_q    <= 1'b0;
      en_q    <= 1'b0;
      sel_q   <= SRC_BUS;
      pres_q  <= 1'b0;
      wide_q  <= 1'b0;
      toval_q <= CNT_W'(TOVAL_INIT);
      win_q   <= '0;
    end else begin
      if (cfg_ok) begin
        upd_q  <= bus_wdata_i[B_UPD];
        ie_q   <= bus_wdata_i[B_IE];
        en_q   <= bus_wdata_i[B_EN];
        sel_q  <= bus_wdata_i[B_SEL +: 2];
        pres_q <= bus_wdata_i[B_PRES];
        wide_q <= bus_wdata_i[B_WIDE];
      end
      if (wr_toval && ulk_q) toval_q <= bus_wdata_i[CNT_W-1:0];
      if (wr_win && ulk_q)   win_q   <= bus_wdata_i[CNT_W-1:0];
    end
  end

  // flag set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flg_q     <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      if (tmo)                               flg_q <= 1'b1;
      else if (wr_ctrl && bus_wdata_i[B_FLG]) flg_q <= 1'b0;
      rst_req_q <= tmo || win_viol;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ulk_q <= 1'b0;
      ut_q  <= '0;
    end else if (cfg_ok) begin
      ulk_q <= 1'b0;
    end else if (key_unlock && upd_q) begin
      ulk_q <= 1'b1;
      ut_q  <= '0;
    end else if (ulk_q) begin
      if (ut_q == UT_W'(UNLK_CYC - 1)) ulk_q <= 1'b0;
      else                             ut_q  <= ut_q + UT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rcs_q <= 1'b1;
      rt_q  <= '0;
    end else if (cfg_ok) begin
      rcs_q <= 1'b0;
      rt_q  <= '0;
    end else if (!rcs_q) begin
      if (rt_q == RT_W'(RCFG_CYC - 1)) rcs_q <= 1'b1;
      else                             rt_q  <= rt_q + RT_W'(1);
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    unique case (reg_e'(bus_addr_i))
      REG_CTRL:  bus_rdata_o = {16'b0, 1'b0, flg_q, wide_q, pres_q, ulk_q, rcs_q,
                                sel_q, en_q, ie_q, upd_q, 5'b0};
      REG_CNT:   bus_rdata_o = 32'(cnt);
      REG_TOVAL: bus_rdata_o = 32'(toval_q);
      default:   bus_rdata_o = 32'(win_q);
    endcase
  end

  assign irq_o     = flg_q && ie_q;
  assign rst_req_o = rst_req_q;

  assert_locked_toval_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_toval && !ulk_q) |=> $stable(toval_q));

  assert_cfg_closes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_ok |=> (!ulk_q && !rcs_q));

  assert_frozen_upd_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(upd_q) |-> !$rose(ulk_q));

  assert_flag_with_reset_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flg_q) |-> rst_req_o);
endmodule

// File: tb/sim_wdog_keyed.sv
`timescale 1ns/1ps
module sim_wdog_keyed;
  localparam int UNLK = 16;
  localparam int RCFG = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        lpo = 1'b0, slow = 1'b0, ext = 1'b0;
  logic        irq, rreq;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  wdog_keyed u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .lpo_tick_i(lpo),
    .slow_tick_i(slow), .ext_tick_i(ext), .irq_o(irq), .rst_req_o(rreq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int src, input int n);
    for (int i = 0; i < n; i++) begin
      if (src == 1) lpo = 1'b1; else if (src == 2) slow = 1'b1; else ext = 1'b1;
      @(negedge clk);
      lpo = 1'b0; slow = 1'b0; ext = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic unlock16(); wr(1, 32'hC520); wr(1, 32'hD928); endtask
  task automatic refresh16(); wr(1, 32'hA602); wr(1, 32'hB480); endtask

  task automatic ulk_bit(input string req, input logic exp);
    logic [31:0] v; rd(0, v); chk(req, {31'b0, v[11]}, {31'b0, exp});
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, v); chk("R1 ctrl", v, 32'h0420);
    rd(2, v); chk("R1 toval", v, 32'hFFFF);
    rd(3, v); chk("R1 win", v, 0);
    rd(1, v); chk("R1 count", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 rst_req", {31'b0, rreq}, 0);
  endtask

  task automatic t_config();
    logic [31:0] v;
    unlock16();
    ulk_bit("R2 unlocked", 1'b1);
    wr(2, 1000); wr(3, 0); wr(0, 32'h00A0);
    rd(0, v);
    chk("R6 closed by ctrl", {31'b0, v[11]}, 0);
    chk("R7 rcs low", {31'b0, v[10]}, 0);
    idle(RCFG - 1); rd(0, v); chk("R7 rcs still low", {31'b0, v[10]}, 0);
    idle(1); rd(0, v); chk("R7 rcs back", {31'b0, v[10]}, 1);
    rd(2, v); chk("R2 toval taken", v, 1000);
  endtask

  task automatic t_refresh_count();
    logic [31:0] v;
    idle(7);
    refresh16(); rd(1, v); chk("R8 refresh clears", v, 0);
    idle(5); rd(1, v); chk("R9 bus clock counting", v, 5);
  endtask

  task automatic t_abort();
    logic [31:0] v;
    wr(1, 32'hC520); wr(1, 32'h1234); wr(1, 32'hD928);
    ulk_bit("R3 wrong half", 1'b0);
    wr(1, 32'hC520); wr(2, 5); wr(1, 32'hD928);
    ulk_bit("R3 intervening write", 1'b0);
    rd(2, v); chk("R5 locked toval ignored", v, 1000);
    wr(3, 9); rd(3, v); chk("R5 locked win ignored", v, 0);
    wr(0, 32'h0000); rd(0, v); chk("R5 locked ctrl ignored", {24'b0, v[7:0]}, 32'hA0);
  endtask

  task automatic t_window_close();
    logic [31:0] v;
    unlock16();
    idle(UNLK - 1); ulk_bit("R6 still open", 1'b1);
    idle(1); ulk_bit("R6 closed by time", 1'b0);
    wr(2, 7); rd(2, v); chk("R6 write after close", v, 1000);
  endtask

  task automatic t_timeout();
    logic [31:0] v;
    unlock16(); wr(2, 20); wr(0, 32'h00E0);
    refresh16();
    idle(19); rd(0, v); chk("R11 flag before", {31'b0, v[14]}, 0);
    chk("R11 no reset early", {31'b0, rreq}, 0);
    idle(1); rd(0, v); chk("R11 flag set", {31'b0, v[14]}, 1);
    chk("R11 reset pulse", {31'b0, rreq}, 1);
    chk("R11 irq", {31'b0, irq}, 1);
    rd(1, v); chk("R11 count wrapped", v, 0);
    idle(1); chk("R11 pulse one cycle", {31'b0, rreq}, 0);
    wr(0, 32'h4000); rd(0, v);
    chk("R11 flag w1c", {31'b0, v[14]}, 0);
    chk("R11 w1c keeps en/ie", {30'b0, v[7:6]}, 3);
    chk("R11 irq cleared", {31'b0, irq}, 0);
  endtask

  task automatic t_window();
    unlock16(); wr(2, 1000); wr(3, 10); wr(0, 32'h00A0);
    idle(12); refresh16();
    chk("R12 late refresh ok", {31'b0, rreq}, 0);
    idle(2); refresh16();
    chk("R12 early refresh resets", {31'b0, rreq}, 1);
  endtask

  task automatic t_sources();
    logic [31:0] v;
    unlock16(); wr(3, 0); wr(0, 32'h01A0);
    refresh16(); idle(4); rd(1, v); chk("R9 lpo ignores bus clock", v, 0);
    pulse(2, 3); pulse(3, 2); rd(1, v); chk("R9 other sources ignored", v, 0);
    pulse(1, 7); rd(1, v); chk("R9 lpo ticks", v, 7);
    unlock16(); wr(0, 32'h12A0);
    refresh16(); pulse(2, 255); rd(1, v); chk("R10 prescale 255", v, 0);
    pulse(2, 1); rd(1, v); chk("R10 prescale 256", v, 1);
  endtask

  task automatic t_wide();
    logic [31:0] v;
    unlock16(); wr(0, 32'h20A0);
    rd(0, v); chk("R4 wide bit", {31'b0, v[13]}, 1);
    unlock16(); ulk_bit("R4 halves ignored", 1'b0);
    wr(1, 32'hD928C520); ulk_bit("R4 wide unlock", 1'b1);
    wr(0, 32'h20A0);
    idle(5); wr(1, 32'hB480A602); rd(1, v); chk("R4 wide refresh", v, 0);
    idle(3); refresh16(); rd(1, v); chk("R4 half refresh ignored", v, 5);
  endtask

  task automatic t_freeze();
    logic [31:0] v;
    wr(1, 32'hD928C520); wr(0, 32'h2080);
    rd(0, v); chk("R13 upd cleared", {31'b0, v[5]}, 0);
    wr(1, 32'hD928C520); ulk_bit("R13 unlock refused", 1'b0);
    wr(2, 3); rd(2, v); chk("R13 toval frozen", v, 1000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_config();
    t_refresh_count();
    t_abort();
    t_window_close();
    t_timeout();
    t_window();
    t_sources();
    t_wide();
    t_freeze();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule